// File: doc/BRIEF.md
# Audio Clock Master Generator

This block produces the bit clock and word clock of an audio serial link when the device acts as clock master. A source clock is divided by a programmable ratio to form the bit clock. The word clock is then derived by counting bit clock periods against a bits-per-frame setting. Each output has its own drive-enable. The pad drives the pin when the enable is high and leaves the pin floating when it is low.

By default both clocks run only while the converter is powered. A keep-alive setting keeps them running while the converter is off. Clocks start cleanly, with both lines low and a full first high phase. They stop only at the end of a frame, after the word clock has returned low and the last bit period has finished, so no shortened pulse reaches the pins. The divider and frame settings are treated as static while the clocks run and are changed only while the clocks are stopped.

Top module: `audio_clk_master`

## Requirements
- R1: `bclk_oe_o` equals `bclk_drv_i` and `wclk_oe_o` equals `wclk_drv_i` in the same cycle, whatever the run state.
- R2: The divide ratio is 128 when `div_code_i` is 0 and N for any other code N. One bit clock period lasts exactly that many source clock cycles.
- R3: For ratios of 2 or more, the bit clock is high for ceil(ratio/2) source cycles and low for floor(ratio/2) cycles. Both changes occur on rising source edges.
- R4: With ratio 1, `bclk_o` follows the source clock while the clocks run: one bit clock pulse per source cycle, high during the source high phase.
- R5: The word clock changes level only when the bit clock falls, and it toggles every `frame_bits_i`/2 bit clock periods. It is low in the first half of each frame and high in the second half.
- R6: When `dac_on_i` and `keep_alive_i` are both 0 and no frame is in progress, `bclk_o` and `wclk_o` stay low. When either input is 1, both clocks run.
- R7: From idle, `bclk_o` rises on the first source rising edge at which a run request is sampled, and `wclk_o` is low at that point.
- R8: After the run request drops, the clocks continue until the word clock has fallen and the bit period in progress has ended. They then hold low, and the last high phase has full length.
- R9: While `rst_ni` is low, `bclk_o` and `wclk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock feeding the divider |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_drv_i | input | 1 | Drive the bit clock pin when high |
| wclk_drv_i | input | 1 | Drive the word clock pin when high |
| div_code_i | input | DIV_W (7) | Divide code; 0 selects 128 |
| frame_bits_i | input | FB_W (8) | Bit clock periods per frame (even, at least 2) |
| dac_on_i | input | 1 | Converter powered-up flag |
| keep_alive_i | input | 1 | Keep clocks running while the converter is off |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock |
| bclk_oe_o | output | 1 | Output enable for the bit clock pad |
| wclk_oe_o | output | 1 | Output enable for the word clock pad |

## Verification
The drive-enables are combinational, so their checks sample 1 ns after the input changes. Divided clocks change on source rising edges. A run request therefore shows as a high bit clock at the very next source edge, and every sample is taken 2 ns after a rising edge, once all registers on the path have settled. Phase lengths, rises per half frame and the stop point are all counted in these sample slots. The pass-through ratio is checked in both source half-periods, and its word clock is sampled after the falling source edge that moves it.

// File: rtl/acg_pkg.sv
package acg_pkg;
  // Per-cycle events of the bit clock divider, in the source clock domain
  typedef struct packed {
    logic fall;  // bit clock goes low at this edge
    logic wrap;  // bit period ends at this edge
  } bit_evt_t;
endpackage

// File: rtl/acg_bclk_div.sv
module acg_bclk_div
  import acg_pkg::*;
#(
  parameter int unsigned DIV_W   = 7,
  localparam int unsigned RATIO_W = DIV_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               act_q_i,
  input  logic               act_d_i,
  output bit_evt_t           evt_o,
  output logic               pass_o,
  output logic               bclk_o
);
  logic [RATIO_W-1:0] cnt_q, cnt_d, pos_nxt, hi_len;
  logic               bclk_q, bclk_d, en_lat_q;

  assign hi_len     = RATIO_W'((ratio_i + RATIO_W'(1)) >> 1);
  assign pass_o     = (ratio_i == RATIO_W'(1));
  assign evt_o.wrap = act_q_i && (cnt_q == ratio_i - RATIO_W'(1));
  assign evt_o.fall = act_q_i && (cnt_q == hi_len - RATIO_W'(1));

  // A fresh start enters position 0 (high phase)
  assign pos_nxt = (!act_q_i || evt_o.wrap) ? '0 : cnt_q + RATIO_W'(1);
  assign cnt_d   = act_d_i ? pos_nxt : '0;
  assign bclk_d  = act_d_i && (pos_nxt < hi_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  // Low-phase enable latch for the pass-through gate
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_lat_q <= 1'b0;
    else         en_lat_q <= act_q_i;
  end

  assign bclk_o = pass_o ? (clk_i & en_lat_q) : bclk_q;

  // R2: position never leaves the programmed period
  a_r2_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q_i |-> (cnt_q < ratio_i));

  // R3: the registered clock is low whenever the divider is idle
  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q_i |-> !bclk_q);
endmodule

// File: rtl/acg_wclk_gen.sv
module acg_wclk_gen #(
  parameter int unsigned FB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FB_W-1:0] frame_bits_i,
  input  logic            act_d_i,
  input  logic            fall_i,
  input  logic            wrap_i,
  input  logic            pass_i,
  output logic            frame_end_o,
  output logic            wclk_o
);
  logic [FB_W-1:0] half, fcnt_q, fcnt_nxt;
  logic            wclk_q, wclk_nxt, wclk_neg_q;

  assign half = (frame_bits_i < FB_W'(2)) ? FB_W'(1) : (frame_bits_i >> 1);

  always_comb begin
    fcnt_nxt = fcnt_q;
    wclk_nxt = wclk_q;
    if (fall_i) begin
      if (fcnt_q == half - FB_W'(1)) begin
        fcnt_nxt = '0;
        wclk_nxt = ~wclk_q;
      end else begin
        fcnt_nxt = fcnt_q + FB_W'(1);
      end
    end
  end

  // Frame closes on the wrap after the word clock has returned low
  assign frame_end_o = wrap_i && (fcnt_nxt == '0) && !wclk_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      wclk_q <= 1'b0;
    end else if (!act_d_i) begin
      fcnt_q <= '0;
      wclk_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_nxt;
      wclk_q <= wclk_nxt;
    end
  end

  // Pass-through: align the word clock with the gated clock's falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wclk_neg_q <= 1'b0;
    else         wclk_neg_q <= wclk_q;
  end

  assign wclk_o = pass_i ? wclk_neg_q : wclk_q;

  // R5: half-frame counter stays inside the half-frame
  a_r5_fcnt_in_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(frame_bits_i) |-> (fcnt_q < half));
endmodule

// File: rtl/acg_run_ctrl.sv
module acg_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic frame_end_i,
  output logic act_q_o,
  output logic act_d_o
);
  logic act_q;

  assign act_d_o = act_q ? !(!req_i && frame_end_i) : req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_d_o;
  end

  assign act_q_o = act_q;

  // R6: a request held over a cycle leaves the clocks running
  a_r6_run_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i) && $past(rst_ni)) |-> act_q);

  // R8: the run state ends only on a frame boundary
  a_r8_stop_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> $past(frame_end_i));
endmodule

// File: rtl/audio_clk_master.sv
module audio_clk_master
  import acg_pkg::*;
#(
  parameter int unsigned DIV_W = 7,
  parameter int unsigned FB_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_drv_i,
  input  logic             wclk_drv_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic [FB_W-1:0]  frame_bits_i,
  input  logic             dac_on_i,
  input  logic             keep_alive_i,
  output logic             bclk_o,
  output logic             wclk_o,
  output logic             bclk_oe_o,
  output logic             wclk_oe_o
);
  localparam int unsigned RATIO_W = DIV_W + 1;

  logic [RATIO_W-1:0] ratio;
  bit_evt_t           evt;
  logic               act_q, act_d, pass, frame_end;

  assign ratio = (div_code_i == '0) ? RATIO_W'(1 << DIV_W) : {1'b0, div_code_i};

  acg_run_ctrl i_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (dac_on_i | keep_alive_i),
    .frame_end_i (frame_end),
    .act_q_o     (act_q),
    .act_d_o     (act_d)
  );

  acg_bclk_div #(.DIV_W(DIV_W)) i_bdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio),
    .act_q_i (act_q),
    .act_d_i (act_d),
    .evt_o   (evt),
    .pass_o  (pass),
    .bclk_o  (bclk_o)
  );

  acg_wclk_gen #(.FB_W(FB_W)) i_wgen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_bits_i (frame_bits_i),
    .act_d_i      (act_d),
    .fall_i       (evt.fall),
    .wrap_i       (evt.wrap),
    .pass_i       (pass),
    .frame_end_o  (frame_end),
    .wclk_o       (wclk_o)
  );

  assign bclk_oe_o = bclk_drv_i;
  assign wclk_oe_o = wclk_drv_i;

  // R5: divided word clock moves only together with a bit clock fall
  a_r5_wclk_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass && !$stable(wclk_o)) |-> $fell(bclk_o));

  // R9: lines low during reset
  always_comb begin
    if (!rst_ni) a_r9_reset_low: assert (!bclk_o && !wclk_o || pass);
  end
endmodule

// File: tb/test_audio_clk_master.sv
`timescale 1ns/1ps
module test_audio_clk_master;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       bclk_drv, wclk_drv, dac_on, keep_alive;
  logic [6:0] div_code;
  logic [7:0] frame_bits;
  logic       bclk_o, wclk_o, bclk_oe_o, wclk_oe_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  int bclk_rises = 0;

  always #2.5 clk = ~clk;
  always @(posedge bclk_o) bclk_rises++;

  audio_clk_master i_audio_clk_master (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bclk_drv_i   (bclk_drv),
    .wclk_drv_i   (wclk_drv),
    .div_code_i   (div_code),
    .frame_bits_i (frame_bits),
    .dac_on_i     (dac_on),
    .keep_alive_i (keep_alive),
    .bclk_o       (bclk_o),
    .wclk_o       (wclk_o),
    .bclk_oe_o    (bclk_oe_o),
    .wclk_oe_o    (wclk_oe_o)
  );

  typedef struct packed {
    logic [6:0] code;
    logic [7:0] fb;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] half;
  } vec_t;

  // code, frame bits, expected high, low, rises per half frame (R2 R3 R5)
  localparam vec_t VECS [7] = '{
    '{7'd4,   8'd32, 8'd2,  8'd2,  8'd16},
    '{7'd5,   8'd16, 8'd3,  8'd2,  8'd8},
    '{7'd2,   8'd8,  8'd1,  8'd1,  8'd4},
    '{7'd3,   8'd64, 8'd2,  8'd1,  8'd32},
    '{7'd0,   8'd4,  8'd64, 8'd64, 8'd2},
    '{7'd7,   8'd2,  8'd4,  8'd3,  8'd1},
    '{7'd127, 8'd6,  8'd64, 8'd63, 8'd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic go_idle(input int n);
    dac_on     = 1'b0;
    keep_alive = 1'b0;
    repeat (n) step();
  endtask

  task automatic measure(output int hi, output int lo, output int rises);
    int   guard;
    logic pw, pb;
    hi = 0; lo = 0; rises = 0; guard = 0;
    pw = wclk_o;
    step();
    while (!(pw == 1'b0 && wclk_o == 1'b1) && guard < 5000) begin
      pw = wclk_o; step(); guard++;
    end
    while (bclk_o == 1'b0 && guard < 5000) begin lo++; step(); guard++; end
    rises = 1;
    while (bclk_o == 1'b1 && guard < 5000) begin hi++; step(); guard++; end
    pb = bclk_o;
    while (wclk_o == 1'b1 && guard < 5000) begin
      step();
      if (!pb && bclk_o) rises++;
      pb = bclk_o;
      guard++;
    end
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, lo, rises, cnt, snap, wfalls, after_fall, last_hi, run_hi;
    logic pb, pw;
    rst_ni = 1'b0; bclk_drv = 1'b0; wclk_drv = 1'b0;
    dac_on = 1'b1; keep_alive = 1'b0; div_code = 7'd4; frame_bits = 8'd8;
    repeat (3) step();
    chk("R9 bclk in reset", int'(bclk_o), 0);
    chk("R9 wclk in reset", int'(wclk_o), 0);
    dac_on = 1'b0;
    step();
    rst_ni = 1'b1;

    // R1: drive enables
    bclk_drv = 1'b1; wclk_drv = 1'b0; #1;
    chk("R1 bclk_oe on", int'(bclk_oe_o), 1);
    chk("R1 wclk_oe off", int'(wclk_oe_o), 0);
    bclk_drv = 1'b0; wclk_drv = 1'b1; #1;
    chk("R1 bclk_oe off", int'(bclk_oe_o), 0);
    chk("R1 wclk_oe on", int'(wclk_oe_o), 1);

    // R6: idle without request
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (bclk_o || wclk_o) cnt++;
    end
    chk("R6 idle lines low", cnt, 0);

    // Vector table: R2 R3 R5
    for (int v = 0; v < 7; v++) begin
      go_idle(1200);
      div_code   = VECS[v].code;
      frame_bits = VECS[v].fb;
      dac_on     = 1'b1;
      measure(hi, lo, rises);
      chk($sformatf("R3 high phase vec%0d", v), hi, int'(VECS[v].hi));
      chk($sformatf("R3 low phase vec%0d", v), lo, int'(VECS[v].lo));
      chk($sformatf("R2 period vec%0d", v), hi + lo, int'(VECS[v].hi) + int'(VECS[v].lo));
      chk($sformatf("R5 rises per half vec%0d", v), rises, int'(VECS[v].half));
    end

    // R7: start from idle
    go_idle(1200);
    div_code = 7'd4; frame_bits = 8'd8;
    dac_on = 1'b1;
    chk("R7 still low before edge", int'(bclk_o), 0);
    step();
    chk("R7 bclk high at first edge", int'(bclk_o), 1);
    chk("R7 wclk low at start", int'(wclk_o), 0);

    // R8: drop request during second half of a frame
    pw = wclk_o;
    step();
    cnt = 0;
    while (!(pw == 1'b0 && wclk_o == 1'b1) && cnt < 1000) begin
      pw = wclk_o; step(); cnt++;
    end
    dac_on = 1'b0;
    rises = 0; wfalls = 0; after_fall = 0; last_hi = 0; run_hi = 0;
    pb = bclk_o; pw = wclk_o;
    for (int i = 0; i < 200; i++) begin
      step();
      if (!pb && bclk_o) begin
        rises++;
        if (wfalls > 0) after_fall++;
      end
      if (pw && !wclk_o) wfalls++;
      if (bclk_o) run_hi++;
      else if (run_hi > 0) begin last_hi = run_hi; run_hi = 0; end
      pb = bclk_o; pw = wclk_o;
    end
    chk("R8 rises until stop", rises, 4);
    chk("R8 single wclk fall", wfalls, 1);
    chk("R8 no rise after frame end", after_fall, 0);
    chk("R8 last high phase full", last_hi, 2);
    chk("R8 bclk parked low", int'(bclk_o), 0);
    chk("R8 wclk parked low", int'(wclk_o), 0);

    // R6: keep-alive alone runs the clocks
    keep_alive = 1'b1;
    rises = 0; pb = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (!pb && bclk_o) rises++;
      pb = bclk_o;
    end
    chk("R6 keep-alive rises", rises, 10);

    // R4: pass-through ratio
    go_idle(200);
    div_code = 7'd1; frame_bits = 8'd4;
    dac_on = 1'b1;
    repeat (4) step();
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (!bclk_o) cnt++;
      #2;
      if (bclk_o) cnt++;
    end
    chk("R4 follows source clock", cnt, 0);
    @(posedge clk); #1;
    snap = bclk_rises;
    repeat (20) @(posedge clk);
    #1;
    chk("R4 one pulse per cycle", bclk_rises - snap, 20);

    // R5: pass-through word clock half frame
    @(posedge clk); #3;
    pw = wclk_o; cnt = 0;
    while (wclk_o == pw && cnt < 100) begin @(posedge clk); #3; cnt++; end
    pw = wclk_o; cnt = 1;
    @(posedge clk); #3;
    while (wclk_o == pw && cnt < 100) begin cnt++; @(posedge clk); #3; end
    chk("R5 pass-through half frame", cnt, 2);

    // R6: request removed, clocks end and stay low
    go_idle(100);
    snap = bclk_rises;
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      step();
      if (wclk_o) cnt++;
    end
    chk("R6 no pulses after stop", bclk_rises - snap, 0);
    chk("R6 wclk low after stop", cnt, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule